// File: doc/BRIEF.md
# Static Memory Controller Configuration Manager

This block keeps the operating state of a static memory controller and the working timing and opmode configuration of each attached chip. The controller is in one of three states: Reset, Ready and Low-power. Software programs a cycles holding register and an opmode holding register, then writes a direct command. The command names a target chip and one of three actions. A register update copies the holding values into that chip's working registers at once. A mode-register write or a memory access is handed to the memory sequencer instead, and the working registers follow only when the sequencer reports that the command has finished.

Because the commit waits for the command to finish, software running from a chip can move that chip to a new operating mode. The old working timing stays in force until the memory itself has taken the new mode. Low-power entry can come from a system request line or from a control register bit, and it is held back while a command is outstanding. The register port is APB-style. It inserts wait states only when a second direct command arrives while one is still outstanding.

Top module: `mm_memory_manager`

## Requirements
- R1: After reset, `mgr_state` is Reset (code 00), `cmd_valid` is low, `pready` is high, and each implemented chip's working cycles and opmode registers hold the parameter defaults `CYC_RST` and `OPM_RST`.
- R2: A write to CTRL (byte address 0x00) controls the state. Bit 2 moves Reset to Ready (code 01). Bit 3 moves Ready or Low-power (code 10) to Reset, takes precedence over the other bits, and drops any outstanding command.
- R3: In Reset and in Low-power, writes to the holding cycles register (0x08), the holding opmode register (0x0C) and the direct-command register (0x04) have no effect, and `cmd_valid` stays low whenever the state is not Ready.
- R4: A direct command is a write to 0x04 with bits [1:0] = chip and bits [3:2] = kind. Kind 00 is a register update: at the accepting clock edge it copies both holding registers into the working registers of the target chip. Those registers read back at 0x40 + 8*chip (cycles) and 0x44 + 8*chip (opmode).
- R5: Kind 01 (mode-register write) and kind 10 (memory access) raise `cmd_valid` with `cmd_chip`, `cmd_kind`, `cmd_cycles` and `cmd_opmode`. These stay stable until `cmd_done` is sampled high. At that edge the target chip's working registers take the dispatched values and `cmd_valid` falls. Before that edge the working registers keep their old values.
- R6: A write to the direct-command register while a command is outstanding sees `pready` low until the outstanding command commits. It is then accepted.
- R7: A commit never changes the working registers of any chip other than its target.
- R8: In Ready, a write of CTRL bit 0 or a rising edge of `lp_req` requests Low-power. The state moves to Low-power once no command is outstanding. Low-power returns to Ready on a write of CTRL bit 1 or a falling edge of `lp_req`.
- R9: Chip slots at or above `NUM_CHIPS` (slot 3 by default) read back as zero, and direct commands that target them are ignored.
- R10: Register reads return zero while the state is Reset.
- R11: `cmd_beats` decodes the dispatched opmode burst-length field at bits [2:0]: 000=1, 001=4, 010=8, 011=16, 100=32, 101=continuous (reported as 0). Other codes give 0.
- R12: `cmd_split` decodes the burst-align field at opmode bits [5:3]: 000 gives 0 (no split), 001 gives the burst length in beats (32 for continuous), 010 gives 64. Other codes give 0.
- R13: `cmd_done` has no effect while no command is outstanding. A direct command with kind 11, or with any bit of [31:4] set, is ignored.
- R14: The holding values are captured when a command is dispatched. A later holding-register write changes neither `cmd_cycles`/`cmd_opmode` nor the values committed for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | ADDR_W | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Register port ready (low inserts a wait) |
| lp_req | input | 1 | System low-power request level |
| mgr_state | output | 2 | Operating state: 00 Reset, 01 Ready, 10 Low-power |
| cmd_valid | output | 1 | A mode-register write or memory access is outstanding |
| cmd_kind | output | 2 | Kind of the outstanding command |
| cmd_chip | output | CHIP_W | Target chip of the outstanding command |
| cmd_cycles | output | CYC_W | Cycles value captured at dispatch |
| cmd_opmode | output | OPM_W | Opmode value captured at dispatch |
| cmd_beats | output | 6 | Decoded burst length of the captured opmode |
| cmd_split | output | 7 | Decoded split boundary in beats of the captured opmode |
| cmd_done | input | 1 | Memory sequencer reports the outstanding command finished |

## Verification
The hardest situation to reach is a second direct command racing an outstanding one. The bench must hold the register port in its access phase while the first command is still pending, and only then finish that command. The stimulus does this by forking the register write against a delayed `cmd_done` pulse, then measuring the wait states and the order in which the two commits land. Two other cases are built from the same pending window: a Low-power request that must wait for the command to complete, and a holding-register write made after dispatch that must not leak into the commit.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'b00,
    ST_READY  = 2'b01,
    ST_LOWPWR = 2'b10
  } mm_state_e;

  typedef enum logic [1:0] {
    DC_REGUPD  = 2'b00,
    DC_MODEREG = 2'b01,
    DC_ACCESS  = 2'b10,
    DC_RSVD    = 2'b11
  } mm_dcmd_e;

  // control register bit positions
  localparam int CTL_LP_SET   = 0;
  localparam int CTL_LP_CLR   = 1;
  localparam int CTL_RUN      = 2;
  localparam int CTL_TO_RESET = 3;

  // opmode field positions
  localparam int OPM_BL_LSB = 0;
  localparam int OPM_AL_LSB = 3;

endpackage

// File: rtl/mm_state_ctrl.sv
module mm_state_ctrl
  import mm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_bits,
  input  logic       lp_req,
  input  logic       cmd_idle,
  output logic [1:0] state
);

  mm_state_e state_q, state_d;
  logic      lp_q;
  logic      pend_q, pend_d;
  logic      lp_rise, lp_fall;
  logic      want_reset, want_run, want_lp, want_wake;

  assign lp_rise    = lp_req & ~lp_q;
  assign lp_fall    = ~lp_req & lp_q;
  assign want_reset = ctrl_wr & ctrl_bits[CTL_TO_RESET];
  assign want_run   = ctrl_wr & ctrl_bits[CTL_RUN];
  assign want_lp    = (ctrl_wr & ctrl_bits[CTL_LP_SET]) | lp_rise;
  assign want_wake  = (ctrl_wr & ctrl_bits[CTL_LP_CLR]) | lp_fall;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_RESET: begin
        pend_d = 1'b0;
        if (want_run && !want_reset) state_d = ST_READY;
      end
      ST_READY: begin
        if (want_reset) begin
          state_d = ST_RESET;
          pend_d  = 1'b0;
        end else begin
          if (want_lp)   pend_d = 1'b1;
          if (want_wake) pend_d = 1'b0;
          if (pend_d && cmd_idle) begin
            state_d = ST_LOWPWR;
            pend_d  = 1'b0;
          end
        end
      end
      ST_LOWPWR: begin
        pend_d = 1'b0;
        if (want_reset)     state_d = ST_RESET;
        else if (want_wake) state_d = ST_READY;
      end
      default: begin
        state_d = ST_RESET;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      pend_q  <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      lp_q    <= lp_req;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/mm_cmd_issue.sv
module mm_cmd_issue
  import mm_pkg::*;
#(
  parameter int NUM_CHIPS = 3,
  parameter int CHIP_W    = 2,
  parameter int CYC_W     = 24,
  parameter int OPM_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ready,
  input  logic              abort,
  input  logic              dc_wr,
  input  logic [CHIP_W+1:0] dc_data,
  input  logic [CYC_W-1:0]  hold_cyc,
  input  logic [OPM_W-1:0]  hold_opm,
  input  logic              cmd_done,
  output logic              busy,
  output logic              idle,
  output logic [CHIP_W-1:0] cmd_chip,
  output logic [1:0]        cmd_kind,
  output logic [CYC_W-1:0]  snap_cyc,
  output logic [OPM_W-1:0]  snap_opm,
  output logic              commit,
  output logic [CHIP_W-1:0] commit_chip,
  output logic [CYC_W-1:0]  commit_cyc,
  output logic [OPM_W-1:0]  commit_opm
);

  localparam logic [CHIP_W:0] NCH = (CHIP_W+1)'(NUM_CHIPS);

  logic              busy_q, busy_d;
  logic [CHIP_W-1:0] chip_q;
  logic [1:0]        kind_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [OPM_W-1:0]  opm_q;

  logic [CHIP_W-1:0] dc_chip;
  mm_dcmd_e          dc_kind;
  logic              chip_ok, accept, reg_now, start, done_now;

  assign dc_chip  = dc_data[CHIP_W-1:0];
  assign dc_kind  = mm_dcmd_e'(dc_data[CHIP_W+1:CHIP_W]);
  assign chip_ok  = {1'b0, dc_chip} < NCH;
  assign accept   = dc_wr && in_ready && !busy_q && chip_ok;
  assign reg_now  = accept && (dc_kind == DC_REGUPD);
  assign start    = accept && ((dc_kind == DC_MODEREG) || (dc_kind == DC_ACCESS));
  assign done_now = busy_q && cmd_done && !abort;

  always_comb begin
    busy_d = busy_q;
    if (abort)         busy_d = 1'b0;
    else if (start)    busy_d = 1'b1;
    else if (done_now) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  // capture of the holding values at dispatch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= '0;
      kind_q <= '0;
      cyc_q  <= '0;
      opm_q  <= '0;
    end else if (start) begin
      chip_q <= dc_chip;
      kind_q <= dc_kind;
      cyc_q  <= hold_cyc;
      opm_q  <= hold_opm;
    end
  end

  assign commit      = reg_now || done_now;
  assign commit_chip = busy_q ? chip_q : dc_chip;
  assign commit_cyc  = busy_q ? cyc_q  : hold_cyc;
  assign commit_opm  = busy_q ? opm_q  : hold_opm;

  assign busy     = busy_q;
  assign idle     = !busy_q && !start;
  assign cmd_chip = chip_q;
  assign cmd_kind = kind_q;
  assign snap_cyc = cyc_q;
  assign snap_opm = opm_q;

endmodule

// File: rtl/mm_cfg_bank.sv
module mm_cfg_bank #(
  parameter int          MAX_CHIPS = 4,
  parameter int          NUM_CHIPS = 3,
  parameter int          CHIP_W    = 2,
  parameter int          CYC_W     = 24,
  parameter int          OPM_W     = 16,
  parameter int unsigned CYC_RST   = 32'h0000_A5A5,
  parameter int unsigned OPM_RST   = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CHIP_W-1:0] commit_chip,
  input  logic [CYC_W-1:0]  commit_cyc,
  input  logic [OPM_W-1:0]  commit_opm,
  input  logic [CHIP_W-1:0] rd_chip,
  output logic [CYC_W-1:0]  rd_cyc,
  output logic [OPM_W-1:0]  rd_opm
);

  logic [CYC_W-1:0] cyc_arr [MAX_CHIPS];
  logic [OPM_W-1:0] opm_arr [MAX_CHIPS];

  for (genvar g = 0; g < MAX_CHIPS; g++) begin : g_chip
    if (g < NUM_CHIPS) begin : g_live
      logic [CYC_W-1:0] cyc_q;
      logic [OPM_W-1:0] opm_q;
      logic             hit;

      assign hit = commit && (commit_chip == CHIP_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cyc_q <= CYC_W'(CYC_RST);
          opm_q <= OPM_W'(OPM_RST);
        end else if (hit) begin
          cyc_q <= commit_cyc;
          opm_q <= commit_opm;
        end
      end

      assign cyc_arr[g] = cyc_q;
      assign opm_arr[g] = opm_q;
    end else begin : g_absent
      assign cyc_arr[g] = '0;
      assign opm_arr[g] = '0;
    end
  end

  assign rd_cyc = cyc_arr[rd_chip];
  assign rd_opm = opm_arr[rd_chip];

endmodule

// File: rtl/mm_burst_decode.sv
module mm_burst_decode (
  input  logic [2:0] bl_code,
  input  logic [2:0] al_code,
  output logic [5:0] beats,
  output logic [6:0] split
);

  always_comb begin
    unique case (bl_code)
      3'b000:  beats = 6'd1;
      3'b001:  beats = 6'd4;
      3'b010:  beats = 6'd8;
      3'b011:  beats = 6'd16;
      3'b100:  beats = 6'd32;
      default: beats = 6'd0;  // continuous and reserved codes
    endcase
  end

  always_comb begin
    unique case (al_code)
      3'b001:  split = (bl_code == 3'b101) ? 7'd32 : {1'b0, beats};
      3'b010:  split = 7'd64;
      default: split = 7'd0;
    endcase
  end

endmodule

// File: rtl/mm_memory_manager.sv
module mm_memory_manager
  import mm_pkg::*;
#(
  parameter int          MAX_CHIPS = 4,
  parameter int          NUM_CHIPS = 3,
  parameter int          CYC_W     = 24,
  parameter int          OPM_W     = 16,
  parameter int          ADDR_W    = 8,
  parameter int unsigned CYC_RST   = 32'h0000_A5A5,
  parameter int unsigned OPM_RST   = 32'h0000_0000,
  localparam int         CHIP_W    = $clog2(MAX_CHIPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              lp_req,
  output logic [1:0]        mgr_state,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [CHIP_W-1:0] cmd_chip,
  output logic [CYC_W-1:0]  cmd_cycles,
  output logic [OPM_W-1:0]  cmd_opmode,
  output logic [5:0]        cmd_beats,
  output logic [6:0]        cmd_split,
  input  logic              cmd_done
);

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DCMD    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_HCYC    = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_HOPM    = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_CFG_END = ADDR_W'(8'h40 + 8 * MAX_CHIPS);
  localparam int                DC_W      = CHIP_W + 2;

  logic              is_ctrl, is_dcmd, is_hcyc, is_hopm;
  logic              wr_acc, ctrl_wr, dc_wr, dc_clean, abort;
  logic              st_ready, st_reset;
  logic              busy, idle;
  logic [CYC_W-1:0]  hold_cyc_q;
  logic [OPM_W-1:0]  hold_opm_q;
  logic              commit;
  logic [CHIP_W-1:0] commit_chip;
  logic [CYC_W-1:0]  commit_cyc;
  logic [OPM_W-1:0]  commit_opm;
  logic [ADDR_W-1:0] cfg_off;
  logic              rd_hit;
  logic [CHIP_W-1:0] rd_chip;
  logic [CYC_W-1:0]  rd_cyc;
  logic [OPM_W-1:0]  rd_opm;

  // address decode
  assign is_ctrl = (paddr == A_CTRL);
  assign is_dcmd = (paddr == A_DCMD);
  assign is_hcyc = (paddr == A_HCYC);
  assign is_hopm = (paddr == A_HOPM);

  assign st_ready = (mgr_state == ST_READY);
  assign st_reset = (mgr_state == ST_RESET);

  // wait only for a direct command that collides with an outstanding one
  assign pready   = !(psel && penable && pwrite && is_dcmd && busy);
  assign wr_acc   = psel && penable && pwrite && pready;
  assign ctrl_wr  = wr_acc && is_ctrl;
  assign dc_clean = (pwdata[31:DC_W] == '0);
  assign dc_wr    = wr_acc && is_dcmd && dc_clean;
  assign abort    = ctrl_wr && pwdata[CTL_TO_RESET] && !st_reset;

  // holding registers, writable only in Ready
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cyc_q <= '0;
      hold_opm_q <= '0;
    end else begin
      if (wr_acc && is_hcyc && st_ready) hold_cyc_q <= pwdata[CYC_W-1:0];
      if (wr_acc && is_hopm && st_ready) hold_opm_q <= pwdata[OPM_W-1:0];
    end
  end

  mm_state_ctrl i_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (pwdata[3:0]),
    .lp_req    (lp_req),
    .cmd_idle  (idle),
    .state     (mgr_state)
  );

  mm_cmd_issue #(
    .NUM_CHIPS (NUM_CHIPS),
    .CHIP_W    (CHIP_W),
    .CYC_W     (CYC_W),
    .OPM_W     (OPM_W)
  ) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (st_ready),
    .abort       (abort),
    .dc_wr       (dc_wr),
    .dc_data     (pwdata[DC_W-1:0]),
    .hold_cyc    (hold_cyc_q),
    .hold_opm    (hold_opm_q),
    .cmd_done    (cmd_done),
    .busy        (busy),
    .idle        (idle),
    .cmd_chip    (cmd_chip),
    .cmd_kind    (cmd_kind),
    .snap_cyc    (cmd_cycles),
    .snap_opm    (cmd_opmode),
    .commit      (commit),
    .commit_chip (commit_chip),
    .commit_cyc  (commit_cyc),
    .commit_opm  (commit_opm)
  );

  assign cmd_valid = busy;

  // read-back of working configuration
  assign cfg_off = paddr - A_CFG;
  assign rd_hit  = (paddr >= A_CFG) && (paddr < A_CFG_END) &&
                   (cfg_off[1:0] == 2'b00) &&
                   (cfg_off[ADDR_W-1:CHIP_W+3] == '0);
  assign rd_chip = cfg_off[CHIP_W+2:3];

  mm_cfg_bank #(
    .MAX_CHIPS (MAX_CHIPS),
    .NUM_CHIPS (NUM_CHIPS),
    .CHIP_W    (CHIP_W),
    .CYC_W     (CYC_W),
    .OPM_W     (OPM_W),
    .CYC_RST   (CYC_RST),
    .OPM_RST   (OPM_RST)
  ) i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_chip (commit_chip),
    .commit_cyc  (commit_cyc),
    .commit_opm  (commit_opm),
    .rd_chip     (rd_chip),
    .rd_cyc      (rd_cyc),
    .rd_opm      (rd_opm)
  );

  always_comb begin
    prdata = '0;
    if (rd_hit && !st_reset) begin
      if (cfg_off[2]) prdata = 32'(rd_opm);
      else            prdata = 32'(rd_cyc);
    end
  end

  mm_burst_decode i_decode (
    .bl_code (cmd_opmode[OPM_BL_LSB +: 3]),
    .al_code (cmd_opmode[OPM_AL_LSB +: 3]),
    .beats   (cmd_beats),
    .split   (cmd_split)
  );

endmodule

// File: rtl/mm_memory_manager_chk.sv
module mm_memory_manager_chk
  import mm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHIP_W = 2,
  parameter int CYC_W  = 24,
  parameter int OPM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              pready,
  input logic [1:0]        mgr_state,
  input logic              cmd_valid,
  input logic              cmd_done,
  input logic [CHIP_W-1:0] cmd_chip,
  input logic [CYC_W-1:0]  cmd_cycles,
  input logic [OPM_W-1:0]  cmd_opmode
);

  logic reset_wr;
  assign reset_wr = psel && penable && pwrite && (paddr == '0) && pwdata[CTL_TO_RESET];

  a_r1_state_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_state != 2'b11);

  a_r2_reset_leaves_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_state == ST_RESET) |=> (mgr_state != ST_LOWPWR));

  a_r3_no_cmd_outside_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_state != ST_READY) |-> !cmd_valid);

  a_r5_cmd_held_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done && !reset_wr) |=>
      (cmd_valid && $stable(cmd_chip) && $stable(cmd_cycles) && $stable(cmd_opmode)));

  a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=> !cmd_valid);

  a_r6_wait_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !pready |-> cmd_valid);

endmodule

bind mm_memory_manager mm_memory_manager_chk #(
  .ADDR_W (ADDR_W),
  .CHIP_W (CHIP_W),
  .CYC_W  (CYC_W),
  .OPM_W  (OPM_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .pready     (pready),
  .mgr_state  (mgr_state),
  .cmd_valid  (cmd_valid),
  .cmd_done   (cmd_done),
  .cmd_chip   (cmd_chip),
  .cmd_cycles (cmd_cycles),
  .cmd_opmode (cmd_opmode)
);

// File: tb/test_mm_memory_manager.sv
`timescale 1ns/100ps
module test_mm_memory_manager;

  localparam int          CYC_W   = 24;
  localparam int          OPM_W   = 16;
  localparam int unsigned CYC_DEF = 32'h0000_A5A5;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_DCMD = 8'h04;
  localparam logic [7:0] A_HCYC = 8'h08;
  localparam logic [7:0] A_HOPM = 8'h0C;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             psel, penable, pwrite;
  logic [7:0]       paddr;
  logic [31:0]      pwdata;
  logic [31:0]      prdata;
  logic             pready;
  logic             lp_req;
  logic [1:0]       mgr_state;
  logic             cmd_valid;
  logic [1:0]       cmd_kind;
  logic [1:0]       cmd_chip;
  logic [CYC_W-1:0] cmd_cycles;
  logic [OPM_W-1:0] cmd_opmode;
  logic [5:0]       cmd_beats;
  logic [6:0]       cmd_split;
  logic             cmd_done;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mm_memory_manager i_mm_memory_manager (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pready     (pready),
    .lp_req     (lp_req),
    .mgr_state  (mgr_state),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_chip   (cmd_chip),
    .cmd_cycles (cmd_cycles),
    .cmd_opmode (cmd_opmode),
    .cmd_beats  (cmd_beats),
    .cmd_split  (cmd_split),
    .cmd_done   (cmd_done)
  );

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [7:0] cfg_a(int chip, bit opm);
    return 8'(8'h40 + 8 * chip + (opm ? 4 : 0));
  endfunction

  function automatic logic [31:0] dcmd(int kind, int chip);
    return 32'((kind << 2) | chip);
  endfunction

  task automatic apb_wr_w(input logic [7:0] a, input logic [31:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    while (!pready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    apb_wr_w(a, d, w);
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "state after reset", 32'(mgr_state), 32'h0);
    chk("R1", "cmd_valid after reset", 32'(cmd_valid), 32'h0);
    chk("R1", "pready after reset", 32'(pready), 32'h1);
    apb_rd(cfg_a(0, 0), d);
    chk("R10", "read in Reset", d, 32'h0);
    apb_wr(A_HCYC, 32'h111);
    apb_wr(A_CTRL, 32'h4);
    chk("R2", "Reset to Ready", 32'(mgr_state), 32'h1);
    apb_rd(cfg_a(0, 0), d);
    chk("R1", "chip0 default cycles", d, CYC_DEF);
    apb_rd(cfg_a(2, 1), d);
    chk("R1", "chip2 default opmode", d, 32'h0);
    apb_rd(cfg_a(3, 0), d);
    chk("R9", "absent chip reads zero", d, 32'h0);
  endtask

  task automatic t_regupd();
    logic [31:0] d;
    // holding write made in Reset must not have landed
    apb_wr(A_DCMD, dcmd(0, 1));
    apb_rd(cfg_a(1, 0), d);
    chk("R3", "hold write in Reset ignored", d, 32'h0);
    apb_wr(A_HCYC, 32'h2222);
    apb_wr(A_HOPM, 32'h0019);
    apb_wr(A_DCMD, dcmd(0, 2));
    chk("R4", "reg update raises no command", 32'(cmd_valid), 32'h0);
    apb_rd(cfg_a(2, 0), d);
    chk("R4", "chip2 cycles committed", d, 32'h2222);
    apb_rd(cfg_a(2, 1), d);
    chk("R4", "chip2 opmode committed", d, 32'h0019);
    apb_rd(cfg_a(0, 0), d);
    chk("R7", "chip0 untouched", d, CYC_DEF);
  endtask

  task automatic t_memcmd();
    logic [31:0] d;
    apb_wr(A_HCYC, 32'h3333);
    apb_wr(A_HOPM, 32'h0013);
    apb_wr(A_DCMD, dcmd(2, 0));
    chk("R5", "cmd_valid on access", 32'(cmd_valid), 32'h1);
    chk("R5", "cmd_chip", 32'(cmd_chip), 32'h0);
    chk("R5", "cmd_kind", 32'(cmd_kind), 32'h2);
    chk("R5", "cmd_cycles", 32'(cmd_cycles), 32'h3333);
    chk("R11", "beats for code 011", 32'(cmd_beats), 32'd16);
    chk("R12", "split for align 010", 32'(cmd_split), 32'd64);
    apb_rd(cfg_a(0, 0), d);
    chk("R5", "working unchanged before done", d, CYC_DEF);
    apb_wr(A_HCYC, 32'h4444);
    chk("R14", "snapshot kept after hold write", 32'(cmd_cycles), 32'h3333);
    pulse_done();
    chk("R5", "cmd_valid falls after done", 32'(cmd_valid), 32'h0);
    apb_rd(cfg_a(0, 0), d);
    chk("R14", "commit uses captured cycles", d, 32'h3333);
    apb_rd(cfg_a(0, 1), d);
    chk("R5", "commit opmode", d, 32'h0013);
    apb_rd(cfg_a(2, 0), d);
    chk("R7", "chip2 untouched by chip0 commit", d, 32'h2222);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    int w;
    apb_wr(A_HOPM, 32'h000D);
    apb_wr(A_DCMD, dcmd(1, 1));
    chk("R11", "continuous reports 0 beats", 32'(cmd_beats), 32'd0);
    chk("R12", "continuous split at 32", 32'(cmd_split), 32'd32);
    fork
      apb_wr_w(A_DCMD, dcmd(2, 2), w);
      begin
        repeat (5) @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
      end
    join
    checks++;
    if (w < 3) begin
      errors++;
      $display("FAIL R6 wait states: actual=%0d expected>=3", w);
    end
    chk("R6", "second command dispatched", 32'(cmd_valid), 32'h1);
    chk("R6", "second command chip", 32'(cmd_chip), 32'h2);
    apb_rd(cfg_a(1, 1), d);
    chk("R6", "first command committed", d, 32'h000D);
    pulse_done();
    apb_wr(A_HOPM, 32'h0009);
    apb_wr(A_DCMD, dcmd(2, 2));
    chk("R11", "beats for code 001", 32'(cmd_beats), 32'd4);
    chk("R12", "split at burst length", 32'(cmd_split), 32'd4);
    pulse_done();
    apb_wr(A_HOPM, 32'h0002);
    apb_wr(A_DCMD, dcmd(1, 0));
    chk("R12", "align 000 no split", 32'(cmd_split), 32'd0);
    chk("R11", "beats for code 010", 32'(cmd_beats), 32'd8);
    pulse_done();
  endtask

  task automatic t_lowpower();
    logic [31:0] d;
    int w;
    apb_wr(A_DCMD, dcmd(2, 0));
    apb_wr(A_CTRL, 32'h1);
    chk("R8", "entry deferred while busy", 32'(mgr_state), 32'h1);
    pulse_done();
    @(negedge clk);
    chk("R8", "enters Low-power after commit", 32'(mgr_state), 32'h2);
    apb_wr(A_HCYC, 32'h5555);
    apb_wr_w(A_DCMD, dcmd(2, 1), w);
    chk("R3", "no wait in Low-power", 32'(w), 32'h0);
    chk("R3", "no command in Low-power", 32'(cmd_valid), 32'h0);
    apb_wr(A_CTRL, 32'h2);
    chk("R8", "clear bit returns to Ready", 32'(mgr_state), 32'h1);
    apb_wr(A_DCMD, dcmd(0, 0));
    apb_rd(cfg_a(0, 0), d);
    chk("R3", "hold write in Low-power ignored", d, 32'h4444);
    @(negedge clk); lp_req = 1'b1;
    @(negedge clk);
    chk("R8", "lp_req rise enters", 32'(mgr_state), 32'h2);
    @(negedge clk); lp_req = 1'b0;
    @(negedge clk);
    chk("R8", "lp_req fall leaves", 32'(mgr_state), 32'h1);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    apb_rd(cfg_a(1, 0), d);
    pulse_done();
    chk("R13", "idle done raises nothing", 32'(cmd_valid), 32'h0);
    apb_rd(cfg_a(1, 0), d);
    chk("R13", "idle done commits nothing", d, 32'h4444);
    apb_wr(A_HCYC, 32'h6666);
    apb_wr(A_DCMD, dcmd(3, 1));
    chk("R13", "reserved kind no command", 32'(cmd_valid), 32'h0);
    apb_wr(A_DCMD, dcmd(0, 1) | 32'h100);
    apb_rd(cfg_a(1, 0), d);
    chk("R13", "reserved bits reject command", d, 32'h4444);
    apb_wr(A_DCMD, dcmd(2, 3));
    chk("R9", "absent chip access ignored", 32'(cmd_valid), 32'h0);
    apb_wr(A_DCMD, dcmd(0, 3));
    apb_rd(cfg_a(3, 0), d);
    chk("R9", "absent chip still zero", d, 32'h0);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    apb_wr(A_DCMD, dcmd(2, 1));
    apb_wr(A_CTRL, 32'hF);
    chk("R2", "reset bit wins", 32'(mgr_state), 32'h0);
    chk("R3", "command dropped", 32'(cmd_valid), 32'h0);
    apb_rd(cfg_a(1, 0), d);
    chk("R10", "read zero in Reset", d, 32'h0);
    apb_wr(A_CTRL, 32'h4);
    apb_rd(cfg_a(1, 0), d);
    chk("R5", "aborted command not committed", d, 32'h4444);
    apb_wr(A_CTRL, 32'h1);
    chk("R8", "bit 0 enters when idle", 32'(mgr_state), 32'h2);
    apb_wr(A_CTRL, 32'h8);
    chk("R2", "Low-power to Reset", 32'(mgr_state), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; lp_req = 1'b0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regupd();
    t_memcmd();
    t_stall();
    t_lowpower();
    t_ignored();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule